// File: doc/BRIEF.md
# DMA Read-Back Sequencer

This block answers processor reads from the control port of a two-channel DMA controller. On every read strobe it registers one byte onto the read data output. Which byte it returns depends on a 7-bit selection mask. Each mask bit picks one of seven items: the live status byte, the two bytes of the running byte counter, and the two bytes each of the running channel A and channel B addresses.

The selected items are packed into a short list in fixed bit order. A pointer walks this list, one entry per read, and returns to the first entry after the last one. The list is rebuilt at three moments: when a new mask byte is written, when a read-status command arrives (this command also narrows the mask to status only), and when an initiate-read-sequence command arrives (this command reuses the mask already held). If no item is selected, every read returns the live status byte.

The status byte is assembled from live controller state each time it is read: enable, ready level against the programmed ready polarity, the operating mode, and the match and end-of-block flags.

Top module: `dma_readback_seq`

## Requirements
- R1: After reset, rd_data_o reads 0x38 and the selection list is empty.
- R2: The status byte always has bits 7, 6, 3 and 2 set, as in the constant 0xCC. Bit 0 equals ctrl_en_i.
- R3: Status bit 1 is 1 when mode_i is not 1 and rdy_lvl_i differs from rdy_pol_i. Otherwise it is 0.
- R4: Status bit 4 is the inverse of match_seen_i. Status bit 5 is the inverse of block_end_i.
- R5: While the selection list is empty, each read returns the live status byte.
- R6: Mask bit k selects item k. The item codes are 0 status, 1 counter low, 2 counter high, 3 A address low, 4 A address high, 5 B address low, 6 B address high. Selected items are returned in ascending bit order.
- R7: After the last selected item has been read, the next read returns the first selected item again.
- R8: Every list rebuild returns the pointer to the first entry.
- R9: A pulse on stat_cmd_i sets the mask to 0x01 (status only) and rebuilds the list.
- R10: A pulse on init_cmd_i rebuilds the list from the mask already held.
- R11: A pulse on mask_wr_i loads mask_i and rebuilds the list in the same cycle. The next read returns the first item of the new mask.
- R12: Counter and address bytes are sampled from the live inputs in the cycle of the read.
- R13: rd_data_o changes only on the clock edge that follows a cycle with rd_i high. The new value appears one cycle after rd_i. If more than one rebuild pulse arrives in the same cycle, mask_wr_i wins over stat_cmd_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mask_wr_i | input | 1 | Load a new selection mask and rebuild the list |
| mask_i | input | 7 | Selection mask value |
| stat_cmd_i | input | 1 | Read-status command: mask becomes status only |
| init_cmd_i | input | 1 | Initiate-read-sequence command: rebuild from the held mask |
| rd_i | input | 1 | Processor read strobe, one read per cycle high |
| ctrl_en_i | input | 1 | Controller enabled |
| mode_i | input | 2 | Operating mode |
| rdy_lvl_i | input | 1 | Current ready input level |
| rdy_pol_i | input | 1 | Programmed ready polarity |
| match_seen_i | input | 1 | A match has occurred |
| block_end_i | input | 1 | End of block reached |
| byte_cnt_i | input | 16 | Running byte counter |
| addr_a_i | input | 16 | Running channel A address |
| addr_b_i | input | 16 | Running channel B address |
| rd_data_o | output | 8 | Registered read data |

## Verification
The hardest case to reach from the ports is a rebuild that happens while the pointer is partway through a list. Two variants of this need checking: the new list is shorter than the old pointer position, and the mask changes under the pointer. The stimulus first reads part of the way into a full or sparse list. It then issues a mask write or a command, and the very next read must return the first entry of the new list. In a separate step, the status item is read from inside a long list after the live flags and counters have been changed between reads. This shows that every byte is sampled at read time and not when the list was built.

// File: rtl/dma_rdseq_pkg.sv
package dma_rdseq_pkg;
  localparam int NUM_ITEMS = 7;
  localparam int PTR_W     = 3;
  localparam int DATA_W    = 8;
  localparam int WORD_W    = 2 * DATA_W;

  typedef enum logic [PTR_W-1:0] {
    ITEM_STAT   = 3'd0,
    ITEM_CNT_LO = 3'd1,
    ITEM_CNT_HI = 3'd2,
    ITEM_A_LO   = 3'd3,
    ITEM_A_HI   = 3'd4,
    ITEM_B_LO   = 3'd5,
    ITEM_B_HI   = 3'd6
  } rd_item_e;
endpackage

// File: rtl/dma_rdseq_status.sv
module dma_rdseq_status
  import dma_rdseq_pkg::*;
#(
  parameter logic [DATA_W-1:0] STAT_BASE   = 8'hCC,
  parameter logic [1:0]        NO_RDY_MODE = 2'd1
) (
  input  logic              ctrl_en_i,
  input  logic [1:0]        mode_i,
  input  logic              rdy_lvl_i,
  input  logic              rdy_pol_i,
  input  logic              match_seen_i,
  input  logic              block_end_i,
  output logic [DATA_W-1:0] status_o
);
  logic rdy_miss;

  // ready mismatch is ignored in the mode that has no ready handshake
  assign rdy_miss = (mode_i != NO_RDY_MODE) && (rdy_lvl_i ^ rdy_pol_i);

  always_comb begin
    status_o    = STAT_BASE;
    status_o[0] = ctrl_en_i;
    status_o[1] = rdy_miss;
    status_o[4] = ~match_seen_i;
    status_o[5] = ~block_end_i;
  end
endmodule

// File: rtl/dma_rdseq_list.sv
module dma_rdseq_list
  import dma_rdseq_pkg::*;
#(
  parameter int N  = NUM_ITEMS,
  parameter int PW = PTR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mask_wr_i,
  input  logic [N-1:0]  mask_i,
  input  logic          stat_cmd_i,
  input  logic          init_cmd_i,
  input  logic          rd_i,
  output rd_item_e      item_o,
  output logic          empty_o,
  output logic [N-1:0]  mask_o,
  output logic [PW-1:0] cnt_o,
  output logic [PW-1:0] ptr_o
);
  localparam logic [N-1:0] STAT_ONLY = N'(1);

  logic [N-1:0]  mask_q, mask_nxt;
  logic [PW-1:0] cnt_q, cnt_nxt, ptr_q, idx;
  logic          rebuild;
  rd_item_e      tbl_q [N];
  rd_item_e      tbl_nxt [N];

  assign rebuild = mask_wr_i | stat_cmd_i | init_cmd_i;

  always_comb begin
    if (mask_wr_i)       mask_nxt = mask_i;
    else if (stat_cmd_i) mask_nxt = STAT_ONLY;
    else                 mask_nxt = mask_q;
  end

  // compact set mask bits into ascending-order list
  always_comb begin
    logic [PW-1:0] pos;
    pos = '0;
    for (int i = 0; i < N; i++) tbl_nxt[i] = ITEM_STAT;
    for (int i = 0; i < N; i++) begin
      if (mask_nxt[i]) begin
        tbl_nxt[pos] = rd_item_e'(i[PW-1:0]);
        pos = pos + PW'(1);
      end
    end
    cnt_nxt = PW'($countones(mask_nxt));
  end

  assign idx     = (ptr_q >= cnt_q) ? '0 : ptr_q;
  assign item_o  = tbl_q[idx];
  assign empty_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      cnt_q  <= '0;
      ptr_q  <= '0;
      for (int i = 0; i < N; i++) tbl_q[i] <= ITEM_STAT;
    end else begin
      if (rebuild) begin
        mask_q <= mask_nxt;
        cnt_q  <= cnt_nxt;
        ptr_q  <= '0;
        for (int i = 0; i < N; i++) tbl_q[i] <= tbl_nxt[i];
      end else if (rd_i && !empty_o) begin
        ptr_q <= idx + PW'(1);
      end
    end
  end

  assign mask_o = mask_q;
  assign cnt_o  = cnt_q;
  assign ptr_o  = ptr_q;
endmodule

// File: rtl/dma_rdseq_mux.sv
module dma_rdseq_mux
  import dma_rdseq_pkg::*;
(
  input  rd_item_e          item_i,
  input  logic [DATA_W-1:0] status_i,
  input  logic [WORD_W-1:0] byte_cnt_i,
  input  logic [WORD_W-1:0] addr_a_i,
  input  logic [WORD_W-1:0] addr_b_i,
  output logic [DATA_W-1:0] byte_o
);
  always_comb begin
    unique case (item_i)
      ITEM_STAT:   byte_o = status_i;
      ITEM_CNT_LO: byte_o = byte_cnt_i[DATA_W-1:0];
      ITEM_CNT_HI: byte_o = byte_cnt_i[WORD_W-1:DATA_W];
      ITEM_A_LO:   byte_o = addr_a_i[DATA_W-1:0];
      ITEM_A_HI:   byte_o = addr_a_i[WORD_W-1:DATA_W];
      ITEM_B_LO:   byte_o = addr_b_i[DATA_W-1:0];
      ITEM_B_HI:   byte_o = addr_b_i[WORD_W-1:DATA_W];
      default:     byte_o = status_i;
    endcase
  end
endmodule

// File: rtl/dma_readback_seq.sv
module dma_readback_seq
  import dma_rdseq_pkg::*;
#(
  parameter logic [DATA_W-1:0] STAT_BASE = 8'hCC,
  parameter logic [DATA_W-1:0] STAT_RST  = 8'h38
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mask_wr_i,
  input  logic [6:0]        mask_i,
  input  logic              stat_cmd_i,
  input  logic              init_cmd_i,
  input  logic              rd_i,
  input  logic              ctrl_en_i,
  input  logic [1:0]        mode_i,
  input  logic              rdy_lvl_i,
  input  logic              rdy_pol_i,
  input  logic              match_seen_i,
  input  logic              block_end_i,
  input  logic [15:0]       byte_cnt_i,
  input  logic [15:0]       addr_a_i,
  input  logic [15:0]       addr_b_i,
  output logic [7:0]        rd_data_o
);
  logic [DATA_W-1:0]    status_live, sel_byte, rd_q;
  logic [NUM_ITEMS-1:0] list_mask;
  logic [PTR_W-1:0]     list_cnt, list_ptr;
  logic                 list_empty;
  rd_item_e             cur_item;

  dma_rdseq_status #(.STAT_BASE(STAT_BASE)) u_status (
    .ctrl_en_i    (ctrl_en_i),
    .mode_i       (mode_i),
    .rdy_lvl_i    (rdy_lvl_i),
    .rdy_pol_i    (rdy_pol_i),
    .match_seen_i (match_seen_i),
    .block_end_i  (block_end_i),
    .status_o     (status_live)
  );

  dma_rdseq_list u_list (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mask_wr_i  (mask_wr_i),
    .mask_i     (mask_i),
    .stat_cmd_i (stat_cmd_i),
    .init_cmd_i (init_cmd_i),
    .rd_i       (rd_i),
    .item_o     (cur_item),
    .empty_o    (list_empty),
    .mask_o     (list_mask),
    .cnt_o      (list_cnt),
    .ptr_o      (list_ptr)
  );

  dma_rdseq_mux u_mux (
    .item_i     (cur_item),
    .status_i   (status_live),
    .byte_cnt_i (byte_cnt_i),
    .addr_a_i   (addr_a_i),
    .addr_b_i   (addr_b_i),
    .byte_o     (sel_byte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rd_q <= STAT_RST;
    else if (rd_i) rd_q <= list_empty ? status_live : sel_byte;
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/dma_readback_seq_chk.sv
module dma_readback_seq_chk
  import dma_rdseq_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 rd_i,
  input logic                 mask_wr_i,
  input logic [NUM_ITEMS-1:0] mask_i,
  input logic                 stat_cmd_i,
  input logic                 init_cmd_i,
  input logic [DATA_W-1:0]    rd_data_o,
  input logic [DATA_W-1:0]    status_live,
  input logic [NUM_ITEMS-1:0] list_mask,
  input logic [PTR_W-1:0]     list_cnt,
  input logic [PTR_W-1:0]     list_ptr
);
  AST_HOLD_NO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rd_data_o)); // R13

  AST_EMPTY_GIVES_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && list_cnt == '0) |=> rd_data_o == $past(status_live)); // R5

  AST_REBUILD_PTR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_wr_i || stat_cmd_i || init_cmd_i) |=> list_ptr == '0); // R8

  AST_PTR_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    list_ptr <= list_cnt); // R7

  AST_STAT_CMD_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_cmd_i && !mask_wr_i) |=> list_mask == NUM_ITEMS'(1)); // R9

  AST_MASK_WR_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_wr_i |=> (list_mask == $past(mask_i)) &&
                  (list_cnt == PTR_W'($countones($past(mask_i))))); // R11

  AST_INIT_KEEPS_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_cmd_i && !mask_wr_i && !stat_cmd_i) |=> $stable(list_mask)); // R10

  always_comb begin
    if (rst_ni) begin
      AST_STATUS_FIXED_BITS: assert ((status_live & 8'hCC) == 8'hCC); // R2
    end
  end
endmodule

bind dma_readback_seq dma_readback_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rd_i        (rd_i),
  .mask_wr_i   (mask_wr_i),
  .mask_i      (mask_i),
  .stat_cmd_i  (stat_cmd_i),
  .init_cmd_i  (init_cmd_i),
  .rd_data_o   (rd_data_o),
  .status_live (status_live),
  .list_mask   (list_mask),
  .list_cnt    (list_cnt),
  .list_ptr    (list_ptr)
);

// File: tb/dma_readback_seq_tb.sv
module dma_readback_seq_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mask_wr_i = 1'b0;
  logic [6:0]  mask_i = '0;
  logic        stat_cmd_i = 1'b0;
  logic        init_cmd_i = 1'b0;
  logic        rd_i = 1'b0;
  logic        ctrl_en_i = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic        rdy_lvl_i = 1'b0;
  logic        rdy_pol_i = 1'b0;
  logic        match_seen_i = 1'b0;
  logic        block_end_i = 1'b0;
  logic [15:0] byte_cnt_i = 16'h1234;
  logic [15:0] addr_a_i = 16'hABCD;
  logic [15:0] addr_b_i = 16'h5678;
  logic [7:0]  rd_data_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk_i = ~clk_i;

  dma_readback_seq u_dut (.*);

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic do_read(input string req, input logic [7:0] exp);
    @(negedge clk_i) rd_i = 1'b1;
    @(negedge clk_i) rd_i = 1'b0;
    check(req, rd_data_o, exp);
  endtask

  task automatic pulse_mask(input logic [6:0] m);
    @(negedge clk_i) begin mask_wr_i = 1'b1; mask_i = m; end
    @(negedge clk_i) mask_wr_i = 1'b0;
  endtask

  task automatic pulse_stat();
    @(negedge clk_i) stat_cmd_i = 1'b1;
    @(negedge clk_i) stat_cmd_i = 1'b0;
  endtask

  task automatic pulse_init();
    @(negedge clk_i) init_cmd_i = 1'b1;
    @(negedge clk_i) init_cmd_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 reset value", rd_data_o, 8'h38);
    // empty list: live status, all flags low -> 0xCC|0x30
    do_read("R1 R5 empty list read", 8'hFC);
  endtask

  task automatic t_status_bits();
    ctrl_en_i = 1; mode_i = 0; rdy_lvl_i = 1; rdy_pol_i = 0; match_seen_i = 0; block_end_i = 0;
    do_read("R2 R3 R4 all set", 8'hFF);
    mode_i = 1;
    do_read("R3 mode 1 masks ready", 8'hFD);
    ctrl_en_i = 0; mode_i = 2; rdy_lvl_i = 1; rdy_pol_i = 1; match_seen_i = 1; block_end_i = 1;
    do_read("R2 R4 flags clear", 8'hCC);
    match_seen_i = 0; rdy_pol_i = 0;
    do_read("R3 R4 match low ready miss", 8'hDE);
    block_end_i = 0; match_seen_i = 1; mode_i = 3; rdy_lvl_i = 0;
    do_read("R4 R5 end low", 8'hEC);
  endtask

  task automatic t_full_mask();
    ctrl_en_i = 1; mode_i = 0; rdy_lvl_i = 0; rdy_pol_i = 0; match_seen_i = 1; block_end_i = 0;
    pulse_mask(7'h7F);
    do_read("R6 item0 status", 8'hED);
    do_read("R6 item1 cnt lo", 8'h34);
    do_read("R6 item2 cnt hi", 8'h12);
    do_read("R6 item3 A lo", 8'hCD);
    do_read("R6 item4 A hi", 8'hAB);
    do_read("R6 item5 B lo", 8'h78);
    do_read("R6 item6 B hi", 8'h56);
    block_end_i = 1;
    do_read("R7 wrap to status", 8'hCD);
  endtask

  task automatic t_sparse();
    pulse_mask(7'b1010110);
    do_read("R6 sparse cnt lo", 8'h34);
    do_read("R6 sparse cnt hi", 8'h12);
    do_read("R6 sparse A hi", 8'hAB);
    do_read("R6 sparse B hi", 8'h56);
    do_read("R7 sparse wrap", 8'h34);
  endtask

  task automatic t_init_rebuild();
    pulse_mask(7'b0101000);
    do_read("R6 A lo", 8'hCD);
    pulse_init();
    do_read("R8 R10 init back to first", 8'hCD);
    do_read("R10 mask kept", 8'h78);
  endtask

  task automatic t_mask_midway();
    pulse_mask(7'h7E);
    do_read("R11 first", 8'h34);
    do_read("R11 second", 8'h12);
    do_read("R11 third", 8'hCD);
    pulse_mask(7'b0000100);
    do_read("R11 R8 new mask first", 8'h12);
    do_read("R7 single wraps", 8'h12);
  endtask

  task automatic t_stat_cmd();
    pulse_mask(7'h7E);
    do_read("R9 before cmd", 8'h34);
    pulse_stat();
    ctrl_en_i = 1; mode_i = 0; rdy_lvl_i = 1; rdy_pol_i = 0; match_seen_i = 0; block_end_i = 0;
    do_read("R9 status only", 8'hFF);
    ctrl_en_i = 0;
    do_read("R9 status only again", 8'hFE);
    pulse_init();
    do_read("R9 R10 init keeps status mask", 8'hFE);
  endtask

  task automatic t_live_values();
    pulse_mask(7'b0000110);
    byte_cnt_i = 16'h9A0F;
    do_read("R12 live cnt lo", 8'h0F);
    byte_cnt_i = 16'h7733;
    do_read("R12 live cnt hi", 8'h77);
  endtask

  task automatic t_hold();
    logic [7:0] held;
    held = rd_data_o;
    byte_cnt_i = 16'h0101; ctrl_en_i = ~ctrl_en_i; block_end_i = ~block_end_i;
    repeat (5) @(negedge clk_i);
    check("R13 output held without read", rd_data_o, held);
    pulse_mask(7'h01);
    check("R13 held across rebuild", rd_data_o, held);
  endtask

  task automatic t_priority();
    pulse_mask(7'h02);
    @(negedge clk_i) begin mask_wr_i = 1; mask_i = 7'h40; stat_cmd_i = 1; end
    @(negedge clk_i) begin mask_wr_i = 0; stat_cmd_i = 0; end
    do_read("R13 mask write beats stat cmd", 8'h56);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_status_bits();
    t_full_mask();
    t_sparse();
    t_init_rebuild();
    t_mask_midway();
    t_stat_cmd();
    t_live_values();
    t_hold();
    t_priority();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule